// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit sits between the opcode decoder and the execute stage of an 8-bit processor with a 16-bit address space. The decoder hands it an addressing-mode code, the one or two operand bytes that follow the opcode, and the current X and Y index values. The unit returns one of three things: a 16-bit effective address, an immediate operand value, or a register target for modes that work on a register instead of memory. Indexed modes add X or Y. The page-zero forms wrap inside page zero. The absolute and post-indexed forms carry into the high byte.

Three modes need a pointer that is stored in memory: pre-indexed, post-indexed and plain indirect. For these the unit reads two bytes through a synchronous byte-read port, low byte first. Read data appears on the cycle after the request. All other modes finish in the cycle right after the request is taken.

Requests enter over a valid/ready handshake. `req_ready` is high only while no pointer fetch is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the inputs are ignored and the requester must hold its request. Each result is marked by `done` for one cycle per request, and the result outputs hold their values until the next result is written. The consumer cannot stall the result.

Top module: `opnd_ea_unit`

## Requirements
- R1: Mode 8 (absolute) gives address = op_lo + 256 × op_hi, with has_addr=1.
- R2: Modes 5 (page zero), 6 (page zero + X) and 7 (page zero + Y) give an address whose low byte is (op_lo + index) mod 256 (index 0 for mode 5) and whose high byte is 0.
- R3: Modes 9 (absolute + X) and 10 (absolute + Y) add the zero-extended index to the 16-bit operand, carry into the high byte, and wrap modulo 65536.
- R4: Mode 12 (pre-indexed) reads the pointer's low byte at 0x00LL, where LL = (op_lo + X) mod 256, then its high byte at 0x00((LL+1) mod 256). The address is that pointer.
- R5: Mode 13 (post-indexed) reads the pointer at 0x00op_lo and 0x00((op_lo+1) mod 256), then adds Y across all 16 bits.
- R6: Mode 11 (plain indirect) reads the pointer at the 16-bit operand address A, then at (A+1) mod 65536. The address is that pointer.
- R7: Mode 4 (immediate) gives value = op_lo. Mode 0 and the unused codes 14 and 15 give nothing. Both give has_addr=0 and is_reg=0, and every non-immediate mode gives value 0.
- R8: Modes 1, 2 and 3 give is_reg=1, has_addr=0 and reg_sel = 1 (accumulator), 2 (X) or 3 (Y).
- R9: A direct mode raises done in the cycle right after the accepting edge. An indirect mode asserts mem_req for exactly two cycles and raises done three cycles later than a direct mode would.
- R10: req_ready is low from the cycle after an indirect request is taken until done. A req_valid presented in that window is ignored: it produces no extra done, and it does not change the pending result.
- R11: After reset, req_ready=1, done=0, mem_req=0, and all result outputs are 0.
- R12: A request taken in the same cycle that done is high is processed normally. The old result holds through that cycle, and the new result appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_req |
| ea_addr | output | 16 | Effective address |
| ea_value | output | 8 | Immediate value |
| ea_has_addr | output | 1 | Result is a memory address |
| ea_is_reg | output | 1 | Result is a register target |
| ea_reg_sel | output | 2 | Register target: 1 A, 2 X, 3 Y |
| done | output | 1 | Result written this cycle |

## Verification
Two events can share a cycle: the done pulse that ends a pointer fetch, and the acceptance of the next request, because req_ready returns in that same cycle. The bench waits for done after a plain-indirect fetch and, in that cycle, presents a page-zero + X request. It checks that the outputs still show the pointer result in that cycle, and that the next cycle shows done again with the wrapped page-zero address. A second test holds req_valid high through a whole fetch and checks that exactly one done arrives, carrying the first request's result.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
  typedef enum logic [3:0] {
    AM_NONE  = 4'd0,
    AM_ACC   = 4'd1,
    AM_REGX  = 4'd2,
    AM_REGY  = 4'd3,
    AM_IMM   = 4'd4,
    AM_ZP    = 4'd5,
    AM_ZPX   = 4'd6,
    AM_ZPY   = 4'd7,
    AM_ABS   = 4'd8,
    AM_ABSX  = 4'd9,
    AM_ABSY  = 4'd10,
    AM_IND   = 4'd11,
    AM_PREX  = 4'd12,
    AM_POSTY = 4'd13,
    AM_RSV14 = 4'd14,
    AM_RSV15 = 4'd15
  } amode_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_A    = 2'd1,
    TGT_X    = 2'd2,
    TGT_Y    = 2'd3
  } tgt_e;
endpackage

// File: rtl/opnd_ea_direct.sv
module opnd_ea_direct #(
  parameter int DATA_W = 8
) (
  input  opnd_ea_pkg::amode_e      mode,
  input  logic [DATA_W-1:0]        op_lo,
  input  logic [DATA_W-1:0]        op_hi,
  input  logic [DATA_W-1:0]        idx_x,
  input  logic [DATA_W-1:0]        idx_y,
  output logic                     need_ptr,
  output logic                     ptr_in_zp,
  output logic [2*DATA_W-1:0]      ptr_loc,
  output logic [DATA_W-1:0]        post_idx,
  output logic                     zp_result,
  output logic [2*DATA_W-1:0]      d_addr,
  output logic [DATA_W-1:0]        d_value,
  output logic                     d_has_addr,
  output logic                     d_is_reg,
  output opnd_ea_pkg::tgt_e        d_sel
);
  import opnd_ea_pkg::*;
  localparam int AW = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ZB = '0;

  logic [AW-1:0] abs_op;
  assign abs_op = {op_hi, op_lo};

  always_comb begin
    need_ptr   = 1'b0;
    ptr_in_zp  = 1'b0;
    ptr_loc    = '0;
    post_idx   = '0;
    zp_result  = 1'b0;
    d_addr     = '0;
    d_value    = '0;
    d_has_addr = 1'b0;
    d_is_reg   = 1'b0;
    d_sel      = TGT_NONE;
    unique case (mode)
      AM_ACC:  begin d_is_reg = 1'b1; d_sel = TGT_A; end
      AM_REGX: begin d_is_reg = 1'b1; d_sel = TGT_X; end
      AM_REGY: begin d_is_reg = 1'b1; d_sel = TGT_Y; end
      AM_IMM:  d_value = op_lo;
      AM_ZP:   begin d_has_addr = 1'b1; zp_result = 1'b1; d_addr = {ZB, op_lo}; end
      AM_ZPX:  begin d_has_addr = 1'b1; zp_result = 1'b1; d_addr = {ZB, op_lo + idx_x}; end
      AM_ZPY:  begin d_has_addr = 1'b1; zp_result = 1'b1; d_addr = {ZB, op_lo + idx_y}; end
      AM_ABS:  begin d_has_addr = 1'b1; d_addr = abs_op; end
      AM_ABSX: begin d_has_addr = 1'b1; d_addr = abs_op + {ZB, idx_x}; end
      AM_ABSY: begin d_has_addr = 1'b1; d_addr = abs_op + {ZB, idx_y}; end
      AM_IND:  begin need_ptr = 1'b1; ptr_loc = abs_op; end
      AM_PREX: begin need_ptr = 1'b1; ptr_in_zp = 1'b1; ptr_loc = {ZB, op_lo + idx_x}; end
      AM_POSTY: begin
        need_ptr = 1'b1; ptr_in_zp = 1'b1; ptr_loc = {ZB, op_lo}; post_idx = idx_y;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_ea_ptr_fetch.sv
module opnd_ea_ptr_fetch #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 ptr_in_zp,
  input  logic [2*DATA_W-1:0]  ptr_loc,
  input  logic [DATA_W-1:0]    post_idx,
  output logic                 busy,
  output logic                 mem_req,
  output logic [2*DATA_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 fin,
  output logic [2*DATA_W-1:0]  fin_addr
);
  localparam int AW = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ZB = '0;

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI, F_JOIN} fstate_e;
  fstate_e       st;
  logic [AW-1:0] loc_q;
  logic          zp_q;
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] lo_q;
  logic [AW-1:0] hi_loc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= F_IDLE;
      loc_q <= '0;
      zp_q  <= 1'b0;
      idx_q <= '0;
      lo_q  <= '0;
    end else begin
      unique case (st)
        F_IDLE: if (start) begin
          loc_q <= ptr_loc;
          zp_q  <= ptr_in_zp;
          idx_q <= post_idx;
          st    <= F_LO;
        end
        F_LO:   st <= F_HI;
        F_HI:   begin lo_q <= mem_rdata; st <= F_JOIN; end
        F_JOIN: st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign hi_loc   = zp_q ? {ZB, loc_q[DATA_W-1:0] + 1'b1} : loc_q + 1'b1;
  assign busy     = (st != F_IDLE);
  assign mem_req  = (st == F_LO) || (st == F_HI);
  assign mem_addr = (st == F_HI) ? hi_loc : loc_q;
  assign fin      = (st == F_JOIN);
  assign fin_addr = {mem_rdata, lo_q} + {ZB, idx_q};

  AST_READ_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |=> mem_req);                                   // R9
  AST_READ_STOPS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |=> !mem_req);                     // R9
  AST_PTR_NEXT_BYTE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) + 1'b1); // R4
  AST_ZP_PTR_PAGE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && zp_q) |-> mem_addr[AW-1:DATA_W] == '0);            // R5
endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          mode,
  input  logic [DATA_W-1:0]   op_lo,
  input  logic [DATA_W-1:0]   op_hi,
  input  logic [DATA_W-1:0]   idx_x,
  input  logic [DATA_W-1:0]   idx_y,
  output logic                mem_req,
  output logic [2*DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2*DATA_W-1:0] ea_addr,
  output logic [DATA_W-1:0]   ea_value,
  output logic                ea_has_addr,
  output logic                ea_is_reg,
  output logic [1:0]          ea_reg_sel,
  output logic                done
);
  import opnd_ea_pkg::*;
  localparam int AW = 2 * DATA_W;

  logic              need_ptr, ptr_in_zp, zp_result, d_has_addr, d_is_reg;
  logic [AW-1:0]     ptr_loc, d_addr, fin_addr;
  logic [DATA_W-1:0] post_idx, d_value;
  tgt_e              d_sel;
  logic              busy, fin, accept, zp_q;

  opnd_ea_direct #(.DATA_W(DATA_W)) u_direct (
    .mode(amode_e'(mode)), .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y),
    .need_ptr(need_ptr), .ptr_in_zp(ptr_in_zp), .ptr_loc(ptr_loc), .post_idx(post_idx),
    .zp_result(zp_result), .d_addr(d_addr), .d_value(d_value),
    .d_has_addr(d_has_addr), .d_is_reg(d_is_reg), .d_sel(d_sel)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  opnd_ea_ptr_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst(rst), .start(accept && need_ptr), .ptr_in_zp(ptr_in_zp),
    .ptr_loc(ptr_loc), .post_idx(post_idx), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .fin(fin), .fin_addr(fin_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_addr     <= '0;
      ea_value    <= '0;
      ea_has_addr <= 1'b0;
      ea_is_reg   <= 1'b0;
      ea_reg_sel  <= TGT_NONE;
      done        <= 1'b0;
      zp_q        <= 1'b0;
    end else begin
      done <= fin || (accept && !need_ptr);
      if (fin) begin
        ea_addr     <= fin_addr;
        ea_value    <= '0;
        ea_has_addr <= 1'b1;
        ea_is_reg   <= 1'b0;
        ea_reg_sel  <= TGT_NONE;
        zp_q        <= 1'b0;
      end else if (accept && !need_ptr) begin
        ea_addr     <= d_addr;
        ea_value    <= d_value;
        ea_has_addr <= d_has_addr;
        ea_is_reg   <= d_is_reg;
        ea_reg_sel  <= d_sel;
        zp_q        <= zp_result;
      end
    end
  end

  AST_REG_NOT_MEM: assert property (@(posedge clk) disable iff (rst)
    done |-> !(ea_is_reg && ea_has_addr));                         // R8
  AST_BUSY_DURING_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);                                       // R10
  AST_ZP_RESULT_PAGE: assert property (@(posedge clk) disable iff (rst)
    (done && zp_q) |-> ea_addr[AW-1:DATA_W] == '0);                // R2
  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(done)) |-> $stable(ea_addr));                 // R10
endmodule

// File: tb/opnd_ea_unit_bench.sv
`timescale 1ns/100ps
module opnd_ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  mode = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] ea_addr;
  logic [7:0]  ea_value;
  logic        ea_has_addr, ea_is_reg, done;
  logic [1:0]  ea_reg_sel;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  logic [15:0] rdlog [4];

  always #2.5 clk = ~clk;

  opnd_ea_unit u_opnd_ea_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .mode(mode),
    .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ea_addr(ea_addr), .ea_value(ea_value),
    .ea_has_addr(ea_has_addr), .ea_is_reg(ea_is_reg), .ea_reg_sel(ea_reg_sel), .done(done)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem_fn(mem_addr);
      rdlog[nreads % 4] <= mem_addr;
      nreads <= nreads + 1;
    end
  end

  // mode lo hi x y | addr value flags{has,isreg,sel} | read0 read1
  localparam int NV = 16;
  localparam logic [95:0] VEC [NV] = '{
    {4'd8,  8'h34, 8'h12, 8'h00, 8'h00, 16'h1234, 8'h00, 4'b1000, 16'h0000, 16'h0000},
    {4'd5,  8'h80, 8'h77, 8'h00, 8'h00, 16'h0080, 8'h00, 4'b1000, 16'h0000, 16'h0000},
    {4'd6,  8'hF0, 8'h00, 8'h20, 8'h00, 16'h0010, 8'h00, 4'b1000, 16'h0000, 16'h0000},
    {4'd7,  8'h7F, 8'h00, 8'h00, 8'h01, 16'h0080, 8'h00, 4'b1000, 16'h0000, 16'h0000},
    {4'd9,  8'hFF, 8'h12, 8'h01, 8'h00, 16'h1300, 8'h00, 4'b1000, 16'h0000, 16'h0000},
    {4'd10, 8'hFF, 8'hFF, 8'h00, 8'h02, 16'h0001, 8'h00, 4'b1000, 16'h0000, 16'h0000},
    {4'd4,  8'hC3, 8'h00, 8'h00, 8'h00, 16'h0000, 8'hC3, 4'b0000, 16'h0000, 16'h0000},
    {4'd1,  8'h11, 8'h22, 8'h00, 8'h00, 16'h0000, 8'h00, 4'b0101, 16'h0000, 16'h0000},
    {4'd2,  8'h11, 8'h22, 8'h00, 8'h00, 16'h0000, 8'h00, 4'b0110, 16'h0000, 16'h0000},
    {4'd3,  8'h11, 8'h22, 8'h00, 8'h00, 16'h0000, 8'h00, 4'b0111, 16'h0000, 16'h0000},
    {4'd0,  8'h55, 8'h66, 8'h00, 8'h00, 16'h0000, 8'h00, 4'b0000, 16'h0000, 16'h0000},
    {4'd12, 8'hFE, 8'h00, 8'h01, 8'h00, 16'hA55A, 8'h00, 4'b1000, 16'h00FF, 16'h0000},
    {4'd12, 8'h10, 8'h00, 8'h05, 8'h00, 16'hB3B0, 8'h00, 4'b1000, 16'h0015, 16'h0016},
    {4'd13, 8'hFF, 8'h00, 8'h00, 8'h10, 16'hA56A, 8'h00, 4'b1000, 16'h00FF, 16'h0000},
    {4'd13, 8'h40, 8'h00, 8'h00, 8'hFF, 16'hE5E4, 8'h00, 4'b1000, 16'h0040, 16'h0041},
    {4'd11, 8'hFF, 8'h12, 8'h00, 8'h00, 16'hB648, 8'h00, 4'b1000, 16'h12FF, 16'h1300}
  };

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd8:            return "R1";
      4'd5, 4'd6, 4'd7: return "R2";
      4'd9, 4'd10:     return "R3";
      4'd12:           return "R4";
      4'd13:           return "R5";
      4'd11:           return "R6";
      4'd1, 4'd2, 4'd3: return "R8";
      default:         return "R7";
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic present(input logic [3:0] m, input logic [7:0] l, input logic [7:0] h,
                         input logic [7:0] x, input logic [7:0] y);
    req_valid = 1'b1; mode = m; op_lo = l; op_hi = h; idx_x = x; idx_y = y;
  endtask

  // Called at a negedge with ready high; returns negedges until done is seen.
  task automatic issue(input logic [3:0] m, input logic [7:0] l, input logic [7:0] h,
                       input logic [7:0] x, input logic [7:0] y, output int lat);
    present(m, l, h, x, y);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int base;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(req_ready === 1'b1, "R11", "ready", req_ready, 1);
    check(done === 1'b0 && mem_req === 1'b0, "R11", "done/mem_req", {done, mem_req}, 0);
    check(ea_addr === 16'h0 && ea_value === 8'h0 && ea_has_addr === 1'b0 &&
          ea_is_reg === 1'b0 && ea_reg_sel === 2'd0, "R11", "outputs", ea_addr, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [95:0] v;
      logic        ind;
      string       t;
      v   = VEC[i];
      ind = v[31:16] != 16'h0 || v[95:92] == 4'd11;
      t   = tag_of(v[95:92]);
      base = nreads;
      issue(v[95:92], v[91:84], v[83:76], v[75:68], v[67:60], lat);
      check(done === 1'b1, t, "done", done, 1);
      check(ea_addr === v[59:44], t, "addr", ea_addr, v[59:44]);
      check(ea_value === v[43:36], t, "value", ea_value, v[43:36]);
      check({ea_has_addr, ea_is_reg, ea_reg_sel} === v[35:32], t, "flags",
            {ea_has_addr, ea_is_reg, ea_reg_sel}, v[35:32]);
      check(lat == (ind ? 4 : 1), "R9", "latency", lat, ind ? 4 : 1);
      check(nreads - base == (ind ? 2 : 0), "R9", "read count", nreads - base, ind ? 2 : 0);
      if (ind) begin
        check(rdlog[base % 4] === v[31:16], t, "first read addr", rdlog[base % 4], v[31:16]);
        check(rdlog[(base + 1) % 4] === v[15:0], t, "second read addr",
              rdlog[(base + 1) % 4], v[15:0]);
      end
      @(negedge clk);
    end

    // R10: request held while busy is ignored
    present(4'd12, 8'h10, 8'h00, 8'h05, 8'h00);
    @(negedge clk);
    present(4'd8, 8'h34, 8'h12, 8'h00, 8'h00);
    for (int k = 0; k < 3; k++) begin
      check(req_ready === 1'b0, "R10", "ready while fetching", req_ready, 0);
      check(done === 1'b0, "R10", "no early done", done, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(done === 1'b1 && ea_addr === 16'hB3B0, "R10", "pending result", ea_addr, 16'hB3B0);
    @(negedge clk);
    check(done === 1'b0, "R10", "no second done", done, 0);
    check(ea_addr === 16'hB3B0, "R10", "result held", ea_addr, 16'hB3B0);

    // R12: new request taken in the done cycle of a pointer fetch
    issue(4'd11, 8'hFF, 8'h12, 8'h00, 8'h00, lat);
    check(done === 1'b1 && ea_addr === 16'hB648, "R12", "old result in done cycle", ea_addr, 16'hB648);
    check(req_ready === 1'b1, "R12", "ready in done cycle", req_ready, 1);
    present(4'd6, 8'hF0, 8'h00, 8'h20, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    check(done === 1'b1, "R12", "second done", done, 1);
    check(ea_addr === 16'h0010, "R12", "new result", ea_addr, 16'h0010);
    @(negedge clk);
    check(done === 1'b0, "R12", "done drops", done, 0);

    // R11: reset again clears results
    rst = 1'b1;
    @(negedge clk);
    check(ea_addr === 16'h0 && done === 1'b0 && req_ready === 1'b1, "R11", "re-reset", ea_addr, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule